// File: doc/BRIEF.md
# Next-Address Unit with Conditional Branch and Jump

This block produces the fetch address for a 16-bit processor whose instructions are one 16-bit word each. It holds a byte-addressed program counter. On each clock edge it moves to the following instruction word, or to a branch or jump target when the decoder says so. Its outputs are the counter itself and the short word index that selects an entry in instruction storage.

The decoder supplies three flags: branch-on-equal, branch-on-not-equal and jump. A register comparator supplies an equality result, and the instruction supplies its 12-bit immediate field. Branch targets are relative to the address of the next instruction, with a signed word offset taken from the low bits of the immediate. Jump targets replace the low part of the incremented counter with the 12-bit field converted to a byte address. Every input is a level sampled at the clock edge. Nothing flows as a stream, so there is no handshake and the block never stalls.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc_o` becomes 0 after that edge, whatever the other inputs are.
- R2: With no control flag set, `pc_o` grows by 2 at each edge. The sum is taken modulo 2^16, and carries reach the upper bits.
- R3: `idx_o` always equals bits 4:1 of `pc_o`, so storage is addressed by word with bit 0 dropped.
- R4: With `br_eq_i` high and `regs_eq_i` high, the next `pc_o` is `pc_o + 2 + (off << 1)`. Here `off` is `imm_i[5:0]` read as a two's-complement number. For example, 24 with offset 1 gives 28.
- R5: With `br_ne_i` high and `regs_eq_i` low, the next `pc_o` is the same branch target as in R4.
- R6: A branch whose condition does not hold (`br_eq_i` with `regs_eq_i` low, or `br_ne_i` with `regs_eq_i` high) advances `pc_o` by exactly 2.
- R7: A negative offset (`imm_i[5]` = 1) moves the counter backwards, and the offset is sign-extended before the shift.
- R8: With `jump_i` high, the next `pc_o` is `{(pc_o+2)[15:13], imm_i[11:0], 1'b0}`. Jump overrides any branch flag, and an all-zero field returns execution to address 0.
- R9: Bit 0 of `pc_o` is 0 at every edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| br_eq_i | input | 1 | Decoded branch-on-equal |
| br_ne_i | input | 1 | Decoded branch-on-not-equal |
| regs_eq_i | input | 1 | The two compared registers are equal |
| jump_i | input | 1 | Decoded unconditional jump |
| imm_i | input | 12 | Instruction immediate: bits 5:0 branch offset, bits 11:0 jump field |
| pc_o | output | 16 | Current byte address |
| idx_o | output | 4 | Instruction storage word index |

## Verification
The bench reaches address 24 by a jump and then takes a branch with offset 1, so that the documented landing at 28 is checked. A unit that added the offset without shifting it, or that branched from the current address rather than the next one, would land at 27 or 26. Backward offsets expose a design that zero-extends, because it would leap forward by about 128 bytes instead of moving back. Branches whose condition fails expose a design that ignores the comparator. Jump combined with branch flags, and a jump to 0x1FFE followed by a plain step across 0x2000, show whether the design has the wrong priority or a truncated adder.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    NXT_STEP   = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_JUMP   = 2'd2,
    NXT_CLEAR  = 2'd3
  } nxt_sel_e;
endpackage

// File: rtl/pcu_branch_eval.sv
module pcu_branch_eval
  import pcu_pkg::*;
(
  input  logic     rst,
  input  logic     br_eq,
  input  logic     br_ne,
  input  logic     regs_eq,
  input  logic     jump,
  output nxt_sel_e sel
);
  logic taken;
  // A branch is taken only when its condition agrees with the comparator.
  assign taken = (br_eq & regs_eq) | (br_ne & ~regs_eq);

  // Priority: reset, then jump, then a taken branch, else step.
  always_comb begin
    if (rst)        sel = NXT_CLEAR;
    else if (jump)  sel = NXT_JUMP;
    else if (taken) sel = NXT_BRANCH;
    else            sel = NXT_STEP;
  end
endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen #(
  parameter int PC_W     = 16,
  parameter int BR_OFF_W = 6,
  parameter int JMP_W    = 12
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [JMP_W-1:0] imm,
  output logic [PC_W-1:0]  step_addr,
  output logic [PC_W-1:0]  branch_addr,
  output logic [PC_W-1:0]  jump_addr
);
  localparam int EXT_W = PC_W - BR_OFF_W - 1;

  logic [PC_W-1:0] br_disp;

  assign step_addr = pc + PC_W'(2);

  // Sign-extend the word offset, then scale to bytes.
  assign br_disp     = {{EXT_W{imm[BR_OFF_W-1]}}, imm[BR_OFF_W-1:0], 1'b0};
  assign branch_addr = step_addr + br_disp;

  generate
    if (JMP_W + 1 < PC_W) begin : g_keep_upper
      assign jump_addr = {step_addr[PC_W-1:JMP_W+1], imm, 1'b0};
    end else begin : g_full_field
      assign jump_addr = {imm[PC_W-2:0], 1'b0};
    end
  endgenerate
endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
  import pcu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  nxt_sel_e        sel,
  input  logic [PC_W-1:0] step_addr,
  input  logic [PC_W-1:0] branch_addr,
  input  logic [PC_W-1:0] jump_addr,
  output logic [PC_W-1:0] next_pc
);
  always_comb begin
    unique case (sel)
      NXT_CLEAR:  next_pc = '0;
      NXT_JUMP:   next_pc = jump_addr;
      NXT_BRANCH: next_pc = branch_addr;
      default:    next_pc = step_addr;
    endcase
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int BR_OFF_W = 6,
  parameter int JMP_W    = 12,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_eq_i,
  input  logic             br_ne_i,
  input  logic             regs_eq_i,
  input  logic             jump_i,
  input  logic [JMP_W-1:0] imm_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [IDX_W-1:0] idx_o
);
  nxt_sel_e        sel;
  logic [PC_W-1:0] step_addr, branch_addr, jump_addr, next_pc;
  logic [PC_W-1:0] pc_q;

  pcu_branch_eval u_eval (
    .rst     (rst),
    .br_eq   (br_eq_i),
    .br_ne   (br_ne_i),
    .regs_eq (regs_eq_i),
    .jump    (jump_i),
    .sel     (sel)
  );

  pcu_target_gen #(.PC_W(PC_W), .BR_OFF_W(BR_OFF_W), .JMP_W(JMP_W)) u_tgt (
    .pc          (pc_q),
    .imm         (imm_i),
    .step_addr   (step_addr),
    .branch_addr (branch_addr),
    .jump_addr   (jump_addr)
  );

  pcu_next_sel #(.PC_W(PC_W)) u_sel (
    .sel         (sel),
    .step_addr   (step_addr),
    .branch_addr (branch_addr),
    .jump_addr   (jump_addr),
    .next_pc     (next_pc)
  );

  always_ff @(posedge clk) begin
    pc_q <= next_pc;
  end

  assign pc_o  = pc_q;
  // Word index: byte address with bit 0 dropped.
  assign idx_o = pc_q[IDX_W:1];
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int PC_W  = 16,
  parameter int JMP_W = 12,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             br_eq_i,
  input logic             br_ne_i,
  input logic             regs_eq_i,
  input logic             jump_i,
  input logic [JMP_W-1:0] imm_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [IDX_W-1:0] idx_o
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> pc_o == '0);

  // R2
  plain_step_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!jump_i && !br_eq_i && !br_ne_i) |=> pc_o == $past(pc_o) + PC_W'(2));

  // R6
  not_taken_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!jump_i && ((br_eq_i && !regs_eq_i && !br_ne_i) || (br_ne_i && regs_eq_i && !br_eq_i)))
    |=> pc_o == $past(pc_o) + PC_W'(2));

  // R8
  jump_field_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    jump_i |=> pc_o[JMP_W:1] == $past(imm_i));

  // R3
  index_chk: assert property (@(posedge clk) disable iff (!seen_rst)
    idx_o == pc_o[IDX_W:1]);

  // R9
  even_addr_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    pc_o[0] == 1'b0);
endmodule

bind pc_next_unit pcu_checker #(.PC_W(PC_W), .JMP_W(JMP_W), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .br_eq_i   (br_eq_i),
  .br_ne_i   (br_ne_i),
  .regs_eq_i (regs_eq_i),
  .jump_i    (jump_i),
  .imm_i     (imm_i),
  .pc_o      (pc_o),
  .idx_o     (idx_o)
);

// File: tb/pc_next_unit_tb_top.sv
`timescale 1ns/1ps
module pc_next_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst, br_eq, br_ne, regs_eq, jump;
  logic [11:0] imm;
  logic [15:0] pc;
  logic [3:0]  idx;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_pc;

  always #4 clk = ~clk;

  pc_next_unit dut_i (
    .clk(clk), .rst(rst), .br_eq_i(br_eq), .br_ne_i(br_ne),
    .regs_eq_i(regs_eq), .jump_i(jump), .imm_i(imm),
    .pc_o(pc), .idx_o(idx)
  );

  function automatic logic [15:0] model_next(logic [15:0] cur, logic r, logic be,
      logic bn, logic eq, logic j, logic [11:0] f);
    logic [15:0] p2;
    p2 = cur + 16'd2;
    if (r) return 16'd0;
    if (j) return {p2[15:13], f, 1'b0};
    if ((be && eq) || (bn && !eq)) return p2 + {{9{f[5]}}, f[5:0], 1'b0};
    return p2;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (pc !== exp_pc) begin
      n_bad++;
      $display("FAIL %s pc: actual %0d expected %0d", tag, pc, exp_pc);
    end
    n_chk++;
    if (idx !== exp_pc[4:1]) begin
      n_bad++;
      $display("FAIL R3 idx: actual %0d expected %0d", idx, exp_pc[4:1]);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, check at the next falling edge.
  task automatic cyc(logic r, logic be, logic bn, logic eq, logic j, logic [11:0] f, string tag);
    rst = r; br_eq = be; br_ne = bn; regs_eq = eq; jump = j; imm = f;
    exp_pc = model_next(exp_pc, r, be, bn, eq, j, f);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    string tg;
    r = $urandom(32'd1234);
    exp_pc = 16'd0;
    rst = 1'b1; br_eq = 0; br_ne = 0; regs_eq = 0; jump = 0; imm = '0;
    @(negedge clk);
    cyc(1, 1, 1, 1, 1, 12'hABC, "R1");
    cyc(0, 0, 0, 0, 0, 12'h000, "R2");
    cyc(0, 0, 0, 1, 0, 12'h03F, "R2");
    cyc(0, 0, 0, 0, 1, 12'd12, "R8");     // jump to 24
    cyc(0, 1, 0, 1, 0, 12'd1, "R4");      // 24 -> 28
    cyc(0, 0, 1, 0, 0, 12'h03D, "R7");    // 28 + 2 - 6 = 24
    cyc(0, 0, 1, 1, 0, 12'h005, "R6");    // bne, equal: step
    cyc(0, 1, 0, 0, 0, 12'h005, "R6");    // beq, unequal: step
    cyc(0, 0, 1, 0, 0, 12'h004, "R5");
    cyc(0, 1, 1, 1, 1, 12'h000, "R8");    // jump wins, to 0
    cyc(0, 0, 0, 0, 1, 12'hFFF, "R8");    // 0x1FFE
    cyc(0, 0, 0, 0, 0, 12'h000, "R2");    // carry into 0x2000
    cyc(0, 1, 0, 1, 0, 12'h020, "R7");    // most negative offset
    cyc(1, 0, 0, 0, 0, 12'h000, "R1");
    for (int i = 0; i < 400; i++) begin
      logic be, bn, eq, j, rr;
      logic [11:0] f;
      r = $urandom;
      rr = (r[3:0] == 4'd0);
      j  = (r[7:5] == 3'd0);
      be = r[8]; bn = r[9]; eq = r[10];
      f  = r[23:12];
      if (rr) tg = "R1";
      else if (j) tg = "R8";
      else if ((be && eq) || (bn && !eq)) tg = f[5] ? "R7" : "R4";
      else if (be || bn) tg = "R6";
      else tg = "R2";
      cyc(rr, be, bn, eq, j, f, tg);
      n_chk++;
      if (pc[0] !== 1'b0) begin
        n_bad++;
        $display("FAIL R9 pc bit0: actual %0b expected 0", pc[0]);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule